// File: doc/BRIEF.md
# Register Rename Map with Squash Rollback

This block is the rename stage's mapping table for an out-of-order core. Integer and floating-point architectural registers are kept in two separate spaces. Each space has its own map table, its own pool of physical registers fed from a circular free list, and its own ready scoreboard. A third, small scoreboard tracks miscellaneous registers, which are never renamed. Each register space has one hardwired zero register that is never given a new physical register.

A rename request names a destination register. In the same cycle the block answers with the physical register it is handing out and the physical register that destination held until now. A separate lookup port translates a source register. Writeback marks a physical register ready, and a query port reads any ready bit back. When the pipeline is flushed, the caller opens a squash window. It then streams undo records, newest first, together with physical registers to give back to the free lists, and closes the window. Renames are held off for as long as the window is open.

Top module: `rename_rollback_map`

## Requirements
- R1: After reset, architectural register i of either space maps to physical register i, the valid flag of every entry reads 0, physical registers below the architectural count read ready, and the ones above them read not ready. Each free count equals the physical count minus the architectural count, and `sqBusy` is 0.
- R2: An accepted rename of a non-zero register returns the free-list head on `renNewPhys` and the prior mapping on `renOldPhys`. After the edge, a lookup of that register returns the new index and the class's free count has dropped by one. After reset the free list hands out indices in ascending order, starting at the architectural count.
- R3: `renOldValid` is 1 only when the map entry has been written, by a rename or an undo record, since reset.
- R4: A rename of the zero register of either space (index 0 by default) is always ready when not squashing. It returns the current mapping on both `renNewPhys` and `renOldPhys`, and it changes neither the table nor the free count.
- R5: A physical register handed out by a rename reads not ready from the next edge on, even if it was marked ready before. A writeback sets the ready bit of the named register. `wbClass` and `qClass` use 0 for integer, 1 for floating point and 2 for miscellaneous.
- R6: A rename in one space leaves the other space's map table and free count unchanged, and it is not blocked by the other space's empty free list.
- R7: When the free list of the requested space is empty, `renReady` is 0 and the cycle allocates nothing and changes no mapping.
- R8: `sqBegin` sets `sqBusy` at the next edge and `sqEnd` clears it at the next edge. While `sqBusy` is 1, `renReady` is 0 for every request.
- R9: While `sqBusy` is 1, each valid undo record writes its previous physical register into the named entry. Undoing two renames of the same register, newest first, restores the mapping it had before both.
- R10: While `sqBusy` is 1, each valid free entry appends its physical register to the tail of its space's free list and raises that space's free count by one. Later renames take the registers in the order they were returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename request present |
| renFp | input | 1 | Request targets the floating-point space |
| renArch | input | AW | Destination architectural register |
| renReady | output | 1 | Request accepted this cycle |
| renNewPhys | output | PW | Physical register granted |
| renOldPhys | output | PW | Physical register previously mapped |
| renOldValid | output | 1 | Previous entry had been written since reset |
| lkFp | input | 1 | Lookup targets the floating-point space |
| lkArch | input | AW | Source architectural register |
| lkPhys | output | PW | Current mapping of the source |
| wbValid | input | 1 | Writeback strobe |
| wbClass | input | 2 | Writeback space: 0 int, 1 fp, 2 misc |
| wbReg | input | PW | Register to mark ready |
| qClass | input | 2 | Query space: 0 int, 1 fp, 2 misc |
| qReg | input | PW | Register to query |
| qReady | output | 1 | Ready bit of the queried register |
| freeIntCount | output | CW | Free integer physical registers |
| freeFpCount | output | CW | Free floating-point physical registers |
| sqBegin | input | 1 | Open the squash window |
| sqEnd | input | 1 | Close the squash window |
| sqBusy | output | 1 | Squash window open |
| sqUndoValid | input | 1 | Undo record present |
| sqUndoFp | input | 1 | Undo record targets floating point |
| sqUndoArch | input | AW | Architectural register to restore |
| sqUndoPhys | input | PW | Mapping to restore |
| sqFreeValid | input | 1 | Register return present |
| sqFreeFp | input | 1 | Returned register is floating point |
| sqFreePhys | input | PW | Physical register to return |

## Verification
The hardest state to reach is a free list that has drained to empty and then wrapped. Reaching it means handing out every spare integer register and hitting the stall. The stimulus then unwinds the whole rename history in one squash window, including two renames of the same register. This leaves the head and tail pointers past the end of storage, with the returned registers in reverse order. The bench drives exactly that sequence, then checks which indices the next renames receive and which mapping the doubly renamed register ends on.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2
  } regClass_e;

  // Strobes from the control module into the datapath
  typedef struct packed {
    logic allocInt;
    logic allocFp;
    logic zeroSel;
    logic undoInt;
    logic undoFp;
    logic pushInt;
    logic pushFp;
  } rmStrobes_t;

endpackage

// File: rtl/rrm_freelist.sv
module rrm_freelist #(
  parameter int DEPTH = 16,
  parameter int FIRST = 8,
  parameter int PW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] pushVal,
  output logic [PW-1:0] head,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SPARE = DEPTH - FIRST;

  logic [PW-1:0] slots [DEPTH];
  logic [IW-1:0] rdPtr, wrPtr;
  logic          doPop, doPush;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
  endfunction

  assign empty  = (count == '0);
  assign head   = slots[rdPtr];
  assign doPop  = pop && !empty;
  assign doPush = push && (count < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) begin
        slots[k] <= (k < SPARE) ? PW'(FIRST + k) : '0;
      end
      rdPtr <= '0;
      wrPtr <= IW'(SPARE % DEPTH);
      count <= CW'(SPARE);
    end else begin
      if (doPush) begin
        slots[wrPtr] <= pushVal;
        wrPtr        <= bump(wrPtr);
      end
      if (doPop) rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rrm_slice.sv
module rrm_slice #(
  parameter int ARCH = 8,
  parameter int PHYS = 16,
  parameter int AW   = 3,
  parameter int PW   = 4,
  parameter int CW   = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          alloc,
  input  logic [AW-1:0] renArch,
  output logic [PW-1:0] curPhys,
  output logic          curValid,
  input  logic [AW-1:0] lkArch,
  output logic [PW-1:0] lkPhys,
  input  logic          undo,
  input  logic [AW-1:0] undoArch,
  input  logic [PW-1:0] undoPhys,
  input  logic          push,
  input  logic [PW-1:0] pushPhys,
  input  logic          wbSet,
  input  logic [PW-1:0] wbReg,
  input  logic [PW-1:0] qReg,
  output logic          qReady,
  output logic [PW-1:0] head,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [PW-1:0]   mapPhys [ARCH];
  logic [ARCH-1:0] mapVld;
  logic [PHYS-1:0] readyBits;

  rrm_freelist #(.DEPTH(PHYS), .FIRST(ARCH), .PW(PW), .CW(CW)) u_freeList (
    .clk(clk), .rstN(rstN), .pop(alloc), .push(push), .pushVal(pushPhys),
    .head(head), .empty(empty), .count(count)
  );

  always_comb begin
    curPhys  = '0;
    curValid = 1'b0;
    lkPhys   = '0;
    qReady   = 1'b0;
    for (int a = 0; a < ARCH; a++) begin
      if (int'(renArch) == a) begin
        curPhys  = mapPhys[a];
        curValid = mapVld[a];
      end
      if (int'(lkArch) == a) lkPhys = mapPhys[a];
    end
    for (int p = 0; p < PHYS; p++) begin
      if (int'(qReg) == p) qReady = readyBits[p];
    end
  end

  // Map table: alloc and undo never coincide (squash window blocks renames)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < ARCH; a++) begin
        mapPhys[a] <= PW'(a);
      end
      mapVld <= '0;
    end else begin
      for (int a = 0; a < ARCH; a++) begin
        if (alloc && int'(renArch) == a) begin
          mapPhys[a] <= head;
          mapVld[a]  <= 1'b1;
        end else if (undo && int'(undoArch) == a) begin
          mapPhys[a] <= undoPhys;
          mapVld[a]  <= 1'b1;
        end
      end
    end
  end

  // Ready scoreboard: a fresh allocation overrides a same-cycle writeback
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PHYS; p++) begin
        readyBits[p] <= (p < ARCH);
      end
    end else begin
      for (int p = 0; p < PHYS; p++) begin
        if (alloc && !empty && int'(head) == p) readyBits[p] <= 1'b0;
        else if (wbSet && int'(wbReg) == p)     readyBits[p] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rrm_ctrl.sv
module rrm_ctrl
  import rrm_pkg::*;
#(
  parameter int AW       = 3,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          renValid,
  input  logic          renFp,
  input  logic [AW-1:0] renArch,
  input  logic          emptyInt,
  input  logic          emptyFp,
  input  logic          sqBegin,
  input  logic          sqEnd,
  input  logic          sqUndoValid,
  input  logic          sqUndoFp,
  input  logic [AW-1:0] sqUndoArch,
  input  logic          sqFreeValid,
  input  logic          sqFreeFp,
  output logic          renReady,
  output logic          busy,
  output rmStrobes_t    stb
);
  logic renZero, undoZero, grant;

  always_comb begin
    renZero  = renFp ? (int'(renArch) == FP_ZERO) : (int'(renArch) == INT_ZERO);
    undoZero = sqUndoFp ? (int'(sqUndoArch) == FP_ZERO) : (int'(sqUndoArch) == INT_ZERO);
    renReady = !busy && (renZero || (renFp ? !emptyFp : !emptyInt));
    grant    = renValid && renReady && !renZero;

    stb.allocInt = grant && !renFp;
    stb.allocFp  = grant && renFp;
    stb.zeroSel  = renZero;
    stb.undoInt  = busy && sqUndoValid && !sqUndoFp && !undoZero;
    stb.undoFp   = busy && sqUndoValid && sqUndoFp && !undoZero;
    stb.pushInt  = busy && sqFreeValid && !sqFreeFp;
    stb.pushFp   = busy && sqFreeValid && sqFreeFp;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        busy <= 1'b0;
    else if (sqEnd)   busy <= 1'b0;
    else if (sqBegin) busy <= 1'b1;
  end
endmodule

// File: rtl/rrm_datapath.sv
module rrm_datapath
  import rrm_pkg::*;
#(
  parameter int ARCH_INT  = 8,
  parameter int PHYS_INT  = 16,
  parameter int ARCH_FP   = 8,
  parameter int PHYS_FP   = 16,
  parameter int MISC_REGS = 4,
  parameter int AW        = 3,
  parameter int PW        = 4,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  rmStrobes_t    stb,
  input  logic          renFp,
  input  logic [AW-1:0] renArch,
  output logic [PW-1:0] renNewPhys,
  output logic [PW-1:0] renOldPhys,
  output logic          renOldValid,
  input  logic          lkFp,
  input  logic [AW-1:0] lkArch,
  output logic [PW-1:0] lkPhys,
  input  logic          wbValid,
  input  logic [1:0]    wbClass,
  input  logic [PW-1:0] wbReg,
  input  logic [1:0]    qClass,
  input  logic [PW-1:0] qReg,
  output logic          qReady,
  input  logic [AW-1:0] sqUndoArch,
  input  logic [PW-1:0] sqUndoPhys,
  input  logic [PW-1:0] sqFreePhys,
  output logic          emptyInt,
  output logic          emptyFp,
  output logic [CW-1:0] freeIntCount,
  output logic [CW-1:0] freeFpCount
);
  logic          sAlloc [2];
  logic          sUndo  [2];
  logic          sPush  [2];
  logic          sWb    [2];
  logic          sCurV  [2];
  logic          sQ     [2];
  logic          sEmpty [2];
  logic [PW-1:0] sCur   [2];
  logic [PW-1:0] sLk    [2];
  logic [PW-1:0] sHead  [2];
  logic [CW-1:0] sCnt   [2];
  logic [MISC_REGS-1:0] miscReady;
  logic miscQ;

  assign sAlloc[0] = stb.allocInt;
  assign sAlloc[1] = stb.allocFp;
  assign sUndo[0]  = stb.undoInt;
  assign sUndo[1]  = stb.undoFp;
  assign sPush[0]  = stb.pushInt;
  assign sPush[1]  = stb.pushFp;
  assign sWb[0]    = wbValid && (wbClass == CLS_INT);
  assign sWb[1]    = wbValid && (wbClass == CLS_FP);

  for (genvar c = 0; c < 2; c++) begin : g_cls
    localparam int A = (c == 0) ? ARCH_INT : ARCH_FP;
    localparam int P = (c == 0) ? PHYS_INT : PHYS_FP;
    rrm_slice #(.ARCH(A), .PHYS(P), .AW(AW), .PW(PW), .CW(CW)) u_slice (
      .clk(clk), .rstN(rstN),
      .alloc(sAlloc[c]), .renArch(renArch), .curPhys(sCur[c]), .curValid(sCurV[c]),
      .lkArch(lkArch), .lkPhys(sLk[c]),
      .undo(sUndo[c]), .undoArch(sqUndoArch), .undoPhys(sqUndoPhys),
      .push(sPush[c]), .pushPhys(sqFreePhys),
      .wbSet(sWb[c]), .wbReg(wbReg), .qReg(qReg), .qReady(sQ[c]),
      .head(sHead[c]), .empty(sEmpty[c]), .count(sCnt[c])
    );
  end

  // Miscellaneous registers: ready tracking only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      miscReady <= '0;
    end else begin
      for (int m = 0; m < MISC_REGS; m++) begin
        if (wbValid && wbClass == CLS_MISC && int'(wbReg) == m) miscReady[m] <= 1'b1;
      end
    end
  end

  always_comb begin
    miscQ = 1'b0;
    for (int m = 0; m < MISC_REGS; m++) begin
      if (int'(qReg) == m) miscQ = miscReady[m];
    end
  end

  always_comb begin
    renOldPhys  = renFp ? sCur[1] : sCur[0];
    renOldValid = renFp ? sCurV[1] : sCurV[0];
    if (stb.zeroSel) renNewPhys = renOldPhys;
    else             renNewPhys = renFp ? sHead[1] : sHead[0];
    lkPhys = lkFp ? sLk[1] : sLk[0];
    case (qClass)
      CLS_INT:  qReady = sQ[0];
      CLS_FP:   qReady = sQ[1];
      CLS_MISC: qReady = miscQ;
      default:  qReady = 1'b0;
    endcase
  end

  assign emptyInt     = sEmpty[0];
  assign emptyFp      = sEmpty[1];
  assign freeIntCount = sCnt[0];
  assign freeFpCount  = sCnt[1];
endmodule

// File: rtl/rename_rollback_map.sv
module rename_rollback_map
  import rrm_pkg::*;
#(
  parameter int ARCH_INT  = 8,
  parameter int PHYS_INT  = 16,
  parameter int ARCH_FP   = 8,
  parameter int PHYS_FP   = 16,
  parameter int MISC_REGS = 4,
  parameter int INT_ZERO  = 0,
  parameter int FP_ZERO   = 0,
  localparam int ARCH_MAX = (ARCH_INT > ARCH_FP) ? ARCH_INT : ARCH_FP,
  localparam int PHYS_MAX = (PHYS_INT > PHYS_FP) ? PHYS_INT : PHYS_FP,
  localparam int AW       = $clog2(ARCH_MAX),
  localparam int PW       = $clog2(PHYS_MAX),
  localparam int CW       = $clog2(PHYS_MAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          renValid,
  input  logic          renFp,
  input  logic [AW-1:0] renArch,
  output logic          renReady,
  output logic [PW-1:0] renNewPhys,
  output logic [PW-1:0] renOldPhys,
  output logic          renOldValid,
  input  logic          lkFp,
  input  logic [AW-1:0] lkArch,
  output logic [PW-1:0] lkPhys,
  input  logic          wbValid,
  input  logic [1:0]    wbClass,
  input  logic [PW-1:0] wbReg,
  input  logic [1:0]    qClass,
  input  logic [PW-1:0] qReg,
  output logic          qReady,
  output logic [CW-1:0] freeIntCount,
  output logic [CW-1:0] freeFpCount,
  input  logic          sqBegin,
  input  logic          sqEnd,
  output logic          sqBusy,
  input  logic          sqUndoValid,
  input  logic          sqUndoFp,
  input  logic [AW-1:0] sqUndoArch,
  input  logic [PW-1:0] sqUndoPhys,
  input  logic          sqFreeValid,
  input  logic          sqFreeFp,
  input  logic [PW-1:0] sqFreePhys
);
  rmStrobes_t stb;
  logic emptyInt, emptyFp;

  rrm_ctrl #(.AW(AW), .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO)) u_ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renFp(renFp), .renArch(renArch),
    .emptyInt(emptyInt), .emptyFp(emptyFp), .sqBegin(sqBegin), .sqEnd(sqEnd),
    .sqUndoValid(sqUndoValid), .sqUndoFp(sqUndoFp), .sqUndoArch(sqUndoArch),
    .sqFreeValid(sqFreeValid), .sqFreeFp(sqFreeFp),
    .renReady(renReady), .busy(sqBusy), .stb(stb)
  );

  rrm_datapath #(
    .ARCH_INT(ARCH_INT), .PHYS_INT(PHYS_INT), .ARCH_FP(ARCH_FP), .PHYS_FP(PHYS_FP),
    .MISC_REGS(MISC_REGS), .AW(AW), .PW(PW), .CW(CW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .renFp(renFp), .renArch(renArch),
    .renNewPhys(renNewPhys), .renOldPhys(renOldPhys), .renOldValid(renOldValid),
    .lkFp(lkFp), .lkArch(lkArch), .lkPhys(lkPhys),
    .wbValid(wbValid), .wbClass(wbClass), .wbReg(wbReg),
    .qClass(qClass), .qReg(qReg), .qReady(qReady),
    .sqUndoArch(sqUndoArch), .sqUndoPhys(sqUndoPhys), .sqFreePhys(sqFreePhys),
    .emptyInt(emptyInt), .emptyFp(emptyFp),
    .freeIntCount(freeIntCount), .freeFpCount(freeFpCount)
  );
endmodule

// File: rtl/rrm_checker.sv
module rrm_checker #(
  parameter int PHYS_INT = 16,
  parameter int PHYS_FP  = 16,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 0,
  parameter int AW       = 3,
  parameter int PW       = 4,
  parameter int CW       = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          renValid,
  input logic          renFp,
  input logic [AW-1:0] renArch,
  input logic          renReady,
  input logic [PW-1:0] renNewPhys,
  input logic [PW-1:0] renOldPhys,
  input logic [CW-1:0] freeIntCount,
  input logic [CW-1:0] freeFpCount,
  input logic          sqBusy
);
  logic intZeroReq, fpZeroReq;
  assign intZeroReq = !renFp && int'(renArch) == INT_ZERO;
  assign fpZeroReq  = renFp && int'(renArch) == FP_ZERO;

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    sqBusy |-> !renReady);

  p_stall_no_alloc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && !renReady && !sqBusy) |=> ($stable(freeIntCount) && $stable(freeFpCount)));

  p_alloc_takes_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && renReady && !renFp && !intZeroReq) |=> (freeIntCount == $past(freeIntCount) - CW'(1)));

  p_zero_no_alloc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && renReady && (intZeroReq || fpZeroReq)) |=>
      ($stable(freeIntCount) && $stable(freeFpCount)));

  p_zero_same_phys_r4: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && (intZeroReq || fpZeroReq)) |-> (renNewPhys == renOldPhys));

  p_fp_isolated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && renReady && renFp) |=> $stable(freeIntCount));

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    (int'(freeIntCount) <= PHYS_INT) && (int'(freeFpCount) <= PHYS_FP));
endmodule

bind rename_rollback_map rrm_checker #(
  .PHYS_INT(PHYS_INT), .PHYS_FP(PHYS_FP), .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO),
  .AW(AW), .PW(PW), .CW(CW)
) u_rrmChk (.*);

// File: tb/rename_rollback_map_bench.sv
`timescale 1ns/1ps
module rename_rollback_map_bench;
  localparam int AW = 3;
  localparam int PW = 4;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic renValid = 1'b0, renFp = 1'b0;
  logic [AW-1:0] renArch = '0;
  logic renReady, renOldValid;
  logic [PW-1:0] renNewPhys, renOldPhys, lkPhys;
  logic lkFp = 1'b0;
  logic [AW-1:0] lkArch = '0;
  logic wbValid = 1'b0;
  logic [1:0] wbClass = 2'd0, qClass = 2'd0;
  logic [PW-1:0] wbReg = '0, qReg = '0;
  logic qReady;
  logic [CW-1:0] freeIntCount, freeFpCount;
  logic sqBegin = 1'b0, sqEnd = 1'b0, sqBusy;
  logic sqUndoValid = 1'b0, sqUndoFp = 1'b0, sqFreeValid = 1'b0, sqFreeFp = 1'b0;
  logic [AW-1:0] sqUndoArch = '0;
  logic [PW-1:0] sqUndoPhys = '0, sqFreePhys = '0;

  always #4 clk = ~clk;

  rename_rollback_map u_rename_rollback_map (.*);

  typedef struct {
    int newP;
    int oldP;
    int oldV;
    string tag;
  } renExp_t;

  renExp_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Monitor: pops one expected item per granted rename
  always @(negedge clk) begin
    #3;
    if (rstN && renValid && renReady) begin
      if (expQ.size() == 0) begin
        chk("R2 unexpected grant", 1, 0);
      end else begin
        renExp_t e;
        e = expQ.pop_front();
        chk({e.tag, " new"}, int'(renNewPhys), e.newP);
        chk({e.tag, " old"}, int'(renOldPhys), e.oldP);
        chk({e.tag, " oldValid (R3)"}, int'(renOldValid), e.oldV);
      end
    end
  end

  // Driver: one rename per call, expectation queued for the monitor
  task automatic doRename(input bit fp, input int arch, input int expNew,
                          input int expOld, input int expV, input string tag);
    renExp_t e;
    @(negedge clk);
    renValid = 1'b1;
    renFp    = fp;
    renArch  = AW'(arch);
    e.newP = expNew; e.oldP = expOld; e.oldV = expV; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    renValid = 1'b0;
    #1;
  endtask

  task automatic chkLookup(input bit fp, input int arch, input int exp, input string req);
    lkFp = fp;
    lkArch = AW'(arch);
    #1;
    chk(req, int'(lkPhys), exp);
  endtask

  task automatic chkReady(input int cls, input int r, input int exp, input string req);
    qClass = 2'(cls);
    qReg = PW'(r);
    #1;
    chk(req, int'(qReady), exp);
  endtask

  task automatic writeback(input int cls, input int r);
    @(negedge clk);
    wbValid = 1'b1;
    wbClass = 2'(cls);
    wbReg = PW'(r);
    @(negedge clk);
    wbValid = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 int free count", int'(freeIntCount), 8);
    chk("R1 fp free count", int'(freeFpCount), 8);
    chk("R1 busy idle", int'(sqBusy), 0);
    chkLookup(1'b0, 3, 3, "R1 int identity map");
    chkLookup(1'b1, 5, 5, "R1 fp identity map");
    chkReady(0, 3, 1, "R1 mapped phys ready");
    chkReady(0, 10, 0, "R1 spare phys not ready");

    // R2/R3 renames in ascending free order
    doRename(1'b0, 3, 8, 3, 0, "R2 first int rename");
    chkLookup(1'b0, 3, 8, "R2 lookup after rename");
    chk("R2 count after one", int'(freeIntCount), 7);
    doRename(1'b0, 3, 9, 8, 1, "R3 second rename same reg");

    // R5 writeback then allocation clears ready
    writeback(0, 12);
    chkReady(0, 12, 1, "R5 writeback sets ready");
    doRename(1'b0, 1, 10, 1, 0, "R2 rename r1");
    doRename(1'b0, 2, 11, 2, 0, "R2 rename r2");
    doRename(1'b0, 4, 12, 4, 0, "R2 rename r4");
    chkReady(0, 12, 0, "R5 allocation clears ready");
    writeback(0, 9);
    chkReady(0, 9, 1, "R5 writeback on renamed");
    writeback(2, 1);
    chkReady(2, 1, 1, "R5 misc ready set");
    chkReady(2, 2, 0, "R5 misc other untouched");

    // R4 zero registers
    doRename(1'b0, 0, 0, 0, 0, "R4 int zero rename");
    chk("R4 int count unchanged", int'(freeIntCount), 3);
    chkLookup(1'b0, 0, 0, "R4 int zero map unchanged");
    doRename(1'b1, 0, 0, 0, 0, "R4 fp zero rename");
    chk("R4 fp count unchanged", int'(freeFpCount), 8);

    // R6 class isolation
    doRename(1'b1, 5, 8, 5, 0, "R6 fp rename");
    chk("R6 fp count", int'(freeFpCount), 7);
    chk("R6 int count untouched", int'(freeIntCount), 3);
    chkLookup(1'b0, 5, 5, "R6 int map untouched");

    // R7 drain and stall
    doRename(1'b0, 5, 13, 5, 0, "R2 rename r5");
    doRename(1'b0, 6, 14, 6, 0, "R2 rename r6");
    doRename(1'b0, 7, 15, 7, 0, "R2 rename r7");
    chk("R7 int empty", int'(freeIntCount), 0);
    @(negedge clk);
    renValid = 1'b1; renFp = 1'b0; renArch = AW'(7);
    #3;
    chk("R7 stall not ready", int'(renReady), 0);
    @(negedge clk);
    renValid = 1'b0;
    #1;
    chk("R7 count stays", int'(freeIntCount), 0);
    chkLookup(1'b0, 7, 15, "R7 map unchanged");
    doRename(1'b1, 2, 9, 2, 0, "R6 fp not blocked by int empty");

    // R8 squash window
    @(negedge clk);
    sqBegin = 1'b1;
    @(negedge clk);
    sqBegin = 1'b0;
    #1;
    chk("R8 busy raised", int'(sqBusy), 1);
    @(negedge clk);
    renValid = 1'b1; renFp = 1'b1; renArch = AW'(3);
    #3;
    chk("R8 rename blocked", int'(renReady), 0);
    @(negedge clk);
    renValid = 1'b0;
    #1;
    chk("R8 fp count held", int'(freeFpCount), 6);

    // R9/R10 undo newest first, return registers
    begin
      int uArch [8] = '{7, 6, 5, 4, 2, 1, 3, 3};
      int uPhys [8] = '{7, 6, 5, 4, 2, 1, 8, 3};
      int fPhys [8] = '{15, 14, 13, 12, 11, 10, 9, 8};
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        sqUndoValid = 1'b1; sqUndoFp = 1'b0;
        sqUndoArch = AW'(uArch[i]); sqUndoPhys = PW'(uPhys[i]);
        sqFreeValid = 1'b1; sqFreeFp = 1'b0; sqFreePhys = PW'(fPhys[i]);
      end
    end
    @(negedge clk);
    sqUndoValid = 1'b0; sqFreeValid = 1'b0; sqEnd = 1'b1;
    @(negedge clk);
    sqEnd = 1'b0;
    #1;
    chk("R8 busy cleared", int'(sqBusy), 0);
    chkLookup(1'b0, 3, 3, "R9 double rename unwound");
    chkLookup(1'b0, 7, 7, "R9 r7 restored");
    chk("R10 int count refilled", int'(freeIntCount), 8);
    chkLookup(1'b1, 5, 8, "R9 fp map untouched by int undo");
    doRename(1'b0, 2, 15, 2, 1, "R10 first returned reg reused");
    doRename(1'b0, 6, 14, 6, 1, "R10 second returned reg reused");
    chk("R10 count after reuse", int'(freeIntCount), 6);

    @(negedge clk);
    chk("R2 expectations drained", expQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule